// File: doc/BRIEF.md
# Indirect Video Memory and Control Register Access Port

This block is the host-facing access path of a video controller. Video memory is not mapped into the host address space. The host first loads a word address into a pointer register. It then streams 16-bit words through a single data command, and each data access steps the pointer forward by one. The pointer holds its value between bursts, so the host reloads it only when it needs to jump elsewhere.

A second pointer and data command fill a small bank of eighteen video control registers in the same streaming way. Bit 7 of the value written to the register pointer is taken as the screen-flip setting. The lower part of video memory holds three background tile planes. Every write there emits a one-cycle dirty strobe that names the plane and the tile, so the renderer can refresh only that tile.

Accesses outside video memory, and register writes beyond the last register, are rejected. They also set a sticky error flag that the host clears on purpose.

Top module: `vram_host_port`

## Requirements
- R1: Commands arrive on `cmd_i` with the encoding 0 idle, 1 load video pointer, 2 video write, 3 video read, 4 load register pointer, 5 register write, 6 clear error. After reset the video pointer, register pointer, flip flag, error flag and all control registers are zero.
- R2: A video write with the pointer below 0x1C00 stores `wdata_i` at the pointer address and increments the pointer.
- R3: A video read with the pointer below 0x1C00 returns the stored word on `rdata_o` with `rdata_valid_o` high in the cycle after the command edge, and increments the pointer.
- R4: A video access with the pointer at 0x1C00 or above leaves the memory unchanged and does not move the pointer. A read in this case still pulses `rdata_valid_o`, with `rdata_o` equal to 0.
- R5: A video write below 0x1800 pulses `dirty_valid_o` for one cycle, in the cycle after the command edge. The pulse carries plane = address bits 12:11 and tile = address bits 10:1. Reads never pulse it, and neither do writes at 0x1800 or above.
- R6: Loading the register pointer keeps `wdata_i` bits 6:0 as the register index and sets `flip_o` to `wdata_i` bit 7.
- R7: A register write with index below 18 stores `wdata_i` in that register and increments the index. Register i appears on `ctrl_regs_o[16*i+15:16*i]`. At index 18 or above the write changes no register and the index does not move.
- R8: `err_o` is set by any out-of-range video access or register write. It stays set until a clear-error command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code, one per cycle |
| wdata_i | input | 16 | Pointer value or data word for the command |
| rdata_o | output | 16 | Video read data |
| rdata_valid_o | output | 1 | Read data valid pulse |
| dirty_valid_o | output | 1 | Tile dirty pulse |
| dirty_plane_o | output | 2 | Plane of the dirty tile |
| dirty_tile_o | output | 10 | Tile index within the plane |
| ctrl_regs_o | output | 288 | Control registers, register i in bits 16*i+15:16*i |
| flip_o | output | 1 | Screen flip setting |
| err_o | output | 1 | Sticky out-of-range flag |

## Verification
The hardest case to observe is that an out-of-range access leaves the pointer where it is. Above 0x1C00, a pointer that stayed put and a pointer that stepped look the same: both return zero. The bench therefore loads the pointer with 0xFFFF and reads twice. A design that stepped would wrap to address 0 and return the word written there earlier, not zero.

Dropped writes are exposed in a similar way. The bench writes at 0x2000, whose low bits alias address 0, and then reads address 0 back. The plane edges at 0x07FF/0x0800 and 0x17FF/0x1800 are crossed inside one burst, so the strobe's plane change and its switch-off are both seen mid-stream.

// File: rtl/gfx_port_pkg.sv
package gfx_port_pkg;
  localparam int unsigned DW = 16;

  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_VADDR  = 3'd1,
    CMD_VWR    = 3'd2,
    CMD_VRD    = 3'd3,
    CMD_RADDR  = 3'd4,
    CMD_RWR    = 3'd5,
    CMD_ERRCLR = 3'd6
  } cmd_e;
endpackage

// File: rtl/vram_store.sv
module vram_store #(
  parameter int unsigned WORDS = 7168,
  parameter int unsigned DW    = 16,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [IW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) q_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/vram_ptr.sv
module vram_ptr #(
  parameter int unsigned AW          = 16,
  parameter int unsigned PLANE_WORDS = 2048,
  parameter int unsigned PLANES      = 3,
  parameter int unsigned VRAM_WORDS  = 7168,
  localparam int unsigned OFS_W      = $clog2(PLANE_WORDS),
  localparam int unsigned PLANE_W    = $clog2(PLANES),
  localparam int unsigned TILE_W     = OFS_W - 1,
  localparam int unsigned TILE_LIMIT = PLANE_WORDS * PLANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               is_wr_i,
  input  logic [AW-1:0]      wdata_i,
  output logic [AW-1:0]      addr_o,
  output logic               in_range_o,
  output logic               oob_o,
  output logic               dirty_valid_o,
  output logic [PLANE_W-1:0] dirty_plane_o,
  output logic [TILE_W-1:0]  dirty_tile_o
);
  localparam logic [AW-1:0] VLIM = AW'(VRAM_WORDS);
  localparam logic [AW-1:0] TLIM = AW'(TILE_LIMIT);

  assign in_range_o = addr_o < VLIM;
  assign oob_o      = step_i && !in_range_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     addr_o <= '0;
    else if (load_i)                 addr_o <= wdata_i;
    else if (step_i && in_range_o)   addr_o <= addr_o + 1'b1;
  end

  // tile strobe: two words per tile, plane picked by upper offset bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_valid_o <= 1'b0;
      dirty_plane_o <= '0;
      dirty_tile_o  <= '0;
    end else begin
      dirty_valid_o <= step_i && is_wr_i && (addr_o < TLIM);
      dirty_plane_o <= addr_o[OFS_W +: PLANE_W];
      dirty_tile_o  <= addr_o[OFS_W-1:1];
    end
  end

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && in_range_o && !load_i |=> addr_o == $past(addr_o) + 1'b1);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oob_o && !load_i |=> $stable(addr_o));
  a_r5_plane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_valid_o |-> 32'(dirty_plane_o) < PLANES);
  a_r5_onecycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_valid_o && !(step_i && is_wr_i) |=> !dirty_valid_o);
endmodule

// File: rtl/ctrl_bank.sv
module ctrl_bank #(
  parameter int unsigned NUM_REGS = 18,
  parameter int unsigned DW       = 16,
  parameter int unsigned IDX_W    = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   idx_ld_i,
  input  logic                   wr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [NUM_REGS*DW-1:0] regs_o,
  output logic                   flip_o,
  output logic                   oob_o
);
  localparam logic [IDX_W-1:0] RLIM = IDX_W'(NUM_REGS);

  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    regs_q [NUM_REGS];

  assign oob_o = wr_i && (idx_q >= RLIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      flip_o <= 1'b0;
    end else if (idx_ld_i) begin
      idx_q  <= wdata_i[IDX_W-1:0];
      flip_o <= wdata_i[IDX_W];
    end else if (wr_i && !oob_o) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_q[i] <= '0;
      else if (wr_i && idx_q == IDX_W'(i))        regs_q[i] <= wdata_i;
    end
    assign regs_o[i*DW +: DW] = regs_q[i];
  end

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !oob_o && !idx_ld_i |=> idx_q == $past(idx_q) + 1'b1);
  a_r7_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oob_o && !idx_ld_i |=> $stable(idx_q) && $stable(regs_o));
  a_r6_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_ld_i |=> $stable(flip_o));
endmodule

// File: rtl/vram_host_port.sv
module vram_host_port
  import gfx_port_pkg::*;
#(
  parameter int unsigned PLANE_WORDS  = 2048,
  parameter int unsigned PLANES       = 3,
  parameter int unsigned SPRITE_WORDS = 1024,
  parameter int unsigned NUM_REGS     = 18,
  localparam int unsigned VRAM_WORDS  = PLANE_WORDS * PLANES + SPRITE_WORDS,
  localparam int unsigned IW          = $clog2(VRAM_WORDS),
  localparam int unsigned PLANE_W     = $clog2(PLANES),
  localparam int unsigned TILE_W      = $clog2(PLANE_WORDS) - 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             cmd_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   rdata_valid_o,
  output logic                   dirty_valid_o,
  output logic [PLANE_W-1:0]     dirty_plane_o,
  output logic [TILE_W-1:0]      dirty_tile_o,
  output logic [NUM_REGS*DW-1:0] ctrl_regs_o,
  output logic                   flip_o,
  output logic                   err_o
);
  cmd_e          cmd;
  logic [DW-1:0] vaddr;
  logic          in_range, vram_oob, reg_oob, rd_oob_q;
  logic [DW-1:0] ram_q;

  assign cmd = cmd_e'(cmd_i);

  vram_ptr #(
    .AW(DW), .PLANE_WORDS(PLANE_WORDS), .PLANES(PLANES), .VRAM_WORDS(VRAM_WORDS)
  ) u_ptr (
    .clk_i, .rst_ni,
    .load_i       (cmd == CMD_VADDR),
    .step_i       (cmd == CMD_VWR || cmd == CMD_VRD),
    .is_wr_i      (cmd == CMD_VWR),
    .wdata_i,
    .addr_o       (vaddr),
    .in_range_o   (in_range),
    .oob_o        (vram_oob),
    .dirty_valid_o, .dirty_plane_o, .dirty_tile_o
  );

  vram_store #(.WORDS(VRAM_WORDS), .DW(DW)) u_mem (
    .clk_i,
    .we_i    (cmd == CMD_VWR && in_range),
    .re_i    (cmd == CMD_VRD && in_range),
    .addr_i  (vaddr[IW-1:0]),
    .wdata_i,
    .q_o     (ram_q)
  );

  ctrl_bank #(.NUM_REGS(NUM_REGS), .DW(DW), .IDX_W(7)) u_regs (
    .clk_i, .rst_ni,
    .idx_ld_i (cmd == CMD_RADDR),
    .wr_i     (cmd == CMD_RWR),
    .wdata_i,
    .regs_o   (ctrl_regs_o),
    .flip_o,
    .oob_o    (reg_oob)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_valid_o <= 1'b0;
      rd_oob_q      <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      rdata_valid_o <= cmd == CMD_VRD;
      rd_oob_q      <= cmd == CMD_VRD && !in_range;
      if (vram_oob || reg_oob)     err_o <= 1'b1;
      else if (cmd == CMD_ERRCLR)  err_o <= 1'b0;
    end
  end

  assign rdata_o = rd_oob_q ? '0 : ram_q;

  a_r8_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_oob || reg_oob |=> err_o);
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && cmd != CMD_ERRCLR |=> err_o);
  a_r3_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd != CMD_VRD |=> !rdata_valid_o);
endmodule

// File: tb/tb_vram_host_port.sv
module tb_vram_host_port;
  import gfx_port_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   cmd = 3'd0;
  logic [15:0]  wdata = '0;
  logic [15:0]  rdata;
  logic         rvalid, dvalid, flip, err;
  logic [1:0]   dplane;
  logic [9:0]   dtile;
  logic [287:0] regs;

  int checks = 0, errors = 0;
  logic [15:0] rd_exp[$];
  int          rd_req[$];
  logic [11:0] dq_exp[$];
  int          dq_req[$];
  logic [15:0] reg_model [18];

  always #2 clk = ~clk;

  vram_host_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_valid_o(rvalid),
    .dirty_valid_o(dvalid), .dirty_plane_o(dplane), .dirty_tile_o(dtile),
    .ctrl_regs_o(regs), .flip_o(flip), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] c, input logic [15:0] d);
    @(negedge clk);
    cmd = c;
    wdata = d;
  endtask

  task automatic idle();
    op(CMD_IDLE, 16'h0);
  endtask

  task automatic vwr(input logic [15:0] d, input bit dirty, input int pl, input int tl, input int req);
    if (dirty) begin
      dq_exp.push_back({2'(pl), 10'(tl)});
      dq_req.push_back(req);
    end
    op(CMD_VWR, d);
  endtask

  task automatic vrd(input logic [15:0] e, input int req);
    rd_exp.push_back(e);
    rd_req.push_back(req);
    op(CMD_VRD, 16'h0);
  endtask

  task automatic rwr(input logic [15:0] d, input int idx);
    if (idx < 18) reg_model[idx] = d;
    op(CMD_RWR, d);
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < 18; i++)
      chk(regs[i*16 +: 16] == reg_model[i], req, regs[i*16 +: 16], reg_model[i]);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rvalid) begin
        if (rd_exp.size() == 0) chk(0, "R3 unexpected read", rdata, 0);
        else begin
          logic [15:0] e;
          int r;
          e = rd_exp.pop_front();
          r = rd_req.pop_front();
          chk(rdata == e, $sformatf("R%0d read data", r), rdata, e);
        end
      end
      if (rst_n && dvalid) begin
        if (dq_exp.size() == 0) chk(0, "R5 unexpected dirty strobe", {dplane, dtile}, 0);
        else begin
          logic [11:0] e;
          int r;
          e = dq_exp.pop_front();
          r = dq_req.pop_front();
          chk({dplane, dtile} == e, $sformatf("R%0d dirty plane/tile", r), {dplane, dtile}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 18; i++) reg_model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(err == 0, "R1 err reset", err, 0);
    chk(flip == 0, "R1 flip reset", flip, 0);
    chk(rvalid == 0 && dvalid == 0, "R1 strobes reset", {rvalid, dvalid}, 0);
    chk_regs("R1 regs reset");

    // R1 pointer starts at 0; R2/R5 writes in plane 0
    vwr(16'hA000, 1, 0, 0, 1);
    vwr(16'hA001, 1, 0, 0, 1);
    // R5 plane crossing 0x07FF -> 0x0800
    op(CMD_VADDR, 16'h07FE);
    vwr(16'h1111, 1, 0, 1023, 5);
    vwr(16'h2222, 1, 0, 1023, 5);
    vwr(16'h3333, 1, 1, 0, 5);
    // R5 last tile word then non-tile area
    op(CMD_VADDR, 16'h17FF);
    vwr(16'h4444, 1, 2, 1023, 5);
    vwr(16'h5555, 0, 0, 0, 5);
    // R4 edge of memory
    op(CMD_VADDR, 16'h1BFE);
    vwr(16'h6666, 0, 0, 0, 2);
    vwr(16'h7777, 0, 0, 0, 2);
    vwr(16'h8888, 0, 0, 0, 4);
    idle();
    chk(err == 1, "R8 err after oob write", err, 1);
    op(CMD_ERRCLR, 16'h0);
    idle();
    chk(err == 0, "R8 err cleared", err, 0);

    // R3 reads stream back
    op(CMD_VADDR, 16'h07FE);
    vrd(16'h1111, 3);
    vrd(16'h2222, 3);
    vrd(16'h3333, 3);
    op(CMD_VADDR, 16'h0);
    vrd(16'hA000, 1);
    vrd(16'hA001, 1);
    op(CMD_VADDR, 16'h17FF);
    vrd(16'h4444, 2);
    vrd(16'h5555, 2);
    op(CMD_VADDR, 16'h1BFE);
    vrd(16'h6666, 2);
    vrd(16'h7777, 2);
    vrd(16'h0000, 4);
    idle();
    chk(err == 1, "R8 err after oob read", err, 1);
    op(CMD_ERRCLR, 16'h0);
    // R4 no increment: a wrap to 0 would return A000
    op(CMD_VADDR, 16'hFFFF);
    vrd(16'h0000, 4);
    vrd(16'h0000, 4);
    // R4 write at alias of address 0 is dropped
    op(CMD_VADDR, 16'h2000);
    vwr(16'hDEAD, 0, 0, 0, 4);
    op(CMD_VADDR, 16'h0);
    vrd(16'hA000, 4);
    idle();
    idle();

    // R6/R7 control registers
    op(CMD_ERRCLR, 16'h0);
    op(CMD_RADDR, 16'h0090);
    idle();
    chk(flip == 1, "R6 flip set by bit 7", flip, 1);
    chk(err == 0, "R8 err clear before reg test", err, 0);
    rwr(16'h0AAA, 16);
    rwr(16'h0BBB, 17);
    rwr(16'h0CCC, 18);
    rwr(16'h0DDD, 18);
    idle();
    chk_regs("R7 writes at 16,17 then ignored at 18");
    chk(err == 1, "R8 err after reg oob", err, 1);
    op(CMD_ERRCLR, 16'h0);
    op(CMD_RADDR, 16'h0005);
    idle();
    chk(flip == 0, "R6 flip cleared", flip, 0);
    rwr(16'h1234, 5);
    rwr(16'h5678, 6);
    op(CMD_RADDR, 16'h00FF);
    rwr(16'h9999, 127);
    idle();
    chk_regs("R7 writes at 5,6 and index 127 ignored");
    chk(flip == 1, "R6 flip from 0xFF", flip, 1);
    chk(err == 1, "R8 err after index 127", err, 1);

    repeat (3) idle();
    chk(rd_exp.size() == 0, "R3 reads outstanding", rd_exp.size(), 0);
    chk(dq_exp.size() == 0, "R5 strobes outstanding", dq_exp.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule